// File: doc/BRIEF.md
# Storage Key Reference/Change Updater

This block keeps one 8-bit storage key for each 4 KiB page of memory and updates it after an address translation has succeeded. A requester presents the absolute address, the kind of access, the configured memory size and the permission flags that translation produced. The block reads the key of the addressed page and sets its referenced bit. On a store it also sets its changed bit. It then writes the key back and returns the permission flags, narrowed where needed.

A load or instruction fetch to a page whose changed bit is still clear returns without write permission. Any later store to that page must then come back through the updater, which lets the changed bit be recorded. Addresses outside the configured memory, or past the depth of the key array, skip the key logic and get their flags back one cycle later. A separate port loads and reads keys directly for initialisation and test.

Top module: `skey_updater`

## Requirements
- R1: A request whose address is greater than or equal to memSize is answered with respValid one cycle after acceptance. Its respFlags equal reqFlags, busy stays low, and no key changes.
- R2: A request whose page number (address shifted right by 12) is not below the key array depth also bypasses as in R1, even when memSize is larger.
- R3: The key updated is the one at index address >> 12. Keys of other pages are left unchanged.
- R4: The access code is 0 load, 1 store, 2 fetch, and 3 is treated as a load. Flags are bit 0 read, bit 1 write, bit 2 execute. For a load or fetch whose key has the change bit (key bit 1, value 0x02) clear, the write flag is cleared and the read and execute flags pass unchanged.
- R5: For a load or fetch whose key has the change bit set, respFlags equal reqFlags.
- R6: A store sets the change bit of the key and returns respFlags equal to reqFlags.
- R7: Every in-range access sets the reference bit (key bit 2, value 0x04). All other key bits are kept.
- R8: After an in-range request is accepted, busy is high for exactly two cycles. respValid pulses for one cycle in the cycle that busy falls, and the updated key is in the array from that cycle. A new request can be accepted in that same cycle.
- R9: A request presented while busy is high is ignored. It produces no response and modifies no key.
- R10: When busy is low, a test write stores tstWkey at index tstIdx. tstRkey always shows the key at tstIdx without delay. A test write presented while busy is high is ignored.
- R11: After reset, busy and respValid are low and every key is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqAddr | input | ADDR_W | Absolute address of the access |
| reqAccess | input | 2 | Access code: 0 load, 1 store, 2 fetch, 3 load |
| reqFlags | input | 3 | Incoming permissions: bit 0 read, bit 1 write, bit 2 execute |
| memSize | input | ADDR_W | Configured memory size in bytes |
| respValid | output | 1 | One-cycle response strobe |
| respFlags | output | 3 | Returned permissions, valid with respValid |
| busy | output | 1 | Read-modify-write of a key in progress |
| tstWe | input | 1 | Test write strobe |
| tstIdx | input | $clog2(NUM_PAGES) | Test port key index |
| tstWkey | input | 8 | Key value for a test write |
| tstRkey | output | 8 | Key stored at tstIdx |

## Verification
The main function is tried with each access kind against keys whose change bit is clear and set, and with keys preloaded with unrelated upper bits. These cases separate the narrowing of the write permission, the setting of the change bit and the keeping of the other key bits. Addresses just below and at the memory size, and a page past the array depth that aliases a live index, show whether the bypass decision uses both limits. Requests and test writes issued while busy show that nothing interleaves with a read-modify-write. A request issued in the cycle a response appears shows that the block accepts it.

// File: rtl/skey_pkg.sv
package skey_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  localparam int FLAG_W   = 3;
  localparam int FL_READ  = 0;
  localparam int FL_WRITE = 1;
  localparam int FL_EXEC  = 2;

  localparam int KEY_W   = 8;
  localparam int KEY_CHG = 1;
  localparam int KEY_REF = 2;

  typedef struct packed {
    logic accept;
    logic bypass;
    logic latch;
    logic commit;
    logic tstWrite;
  } strobe_t;

endpackage

// File: rtl/skey_ctrl.sv
module skey_ctrl
  import skey_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    inRange,
  input  logic    tstWe,
  output strobe_t stb,
  output logic    busy,
  output logic    respValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_e;
  state_e state, stateNext;

  always_comb begin
    stb          = '0;
    stb.accept   = (state == ST_IDLE) && reqValid;
    stb.bypass   = stb.accept && !inRange;
    stb.latch    = (state == ST_READ);
    stb.commit   = (state == ST_WRITE);
    stb.tstWrite = (state == ST_IDLE) && tstWe;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (stb.accept && inRange) stateNext = ST_READ;
      ST_READ:  stateNext = ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      respValid <= 1'b0;
    end else begin
      state     <= stateNext;
      respValid <= stb.bypass || stb.commit;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/skey_datapath.sv
module skey_datapath
  import skey_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  strobe_t                      stb,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [1:0]                   reqAccess,
  input  logic [FLAG_W-1:0]            reqFlags,
  input  logic [ADDR_W-1:0]            memSize,
  input  logic [$clog2(NUM_PAGES)-1:0] tstIdx,
  input  logic [KEY_W-1:0]             tstWkey,
  output logic                         inRange,
  output logic [FLAG_W-1:0]            respFlags,
  output logic [KEY_W-1:0]             tstRkey,
  output access_e                      capAccess,
  output logic [FLAG_W-1:0]            capFlags,
  output logic [KEY_W-1:0]             wbKey
);

  localparam int IDX_W = $clog2(NUM_PAGES);

  logic [KEY_W-1:0]  keyRam [NUM_PAGES];
  logic [IDX_W-1:0]  capIdx;
  logic [ADDR_W-1:0] pageNum;
  logic [KEY_W-1:0]  curKey, nextKey;
  logic [FLAG_W-1:0] nextFlags;
  logic              isStore;

  assign pageNum = reqAddr >> PAGE_BITS;
  assign inRange = (reqAddr < memSize) && (pageNum < ADDR_W'(NUM_PAGES));

  assign curKey  = keyRam[capIdx];
  assign isStore = (capAccess == ACC_STORE);

  always_comb begin
    nextKey          = curKey;
    nextKey[KEY_REF] = 1'b1;
    if (isStore) nextKey[KEY_CHG] = 1'b1;
    nextFlags = capFlags;
    if (!isStore && !curKey[KEY_CHG]) nextFlags[FL_WRITE] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capIdx    <= '0;
      capAccess <= ACC_LOAD;
      capFlags  <= '0;
      respFlags <= '0;
      wbKey     <= '0;
    end else begin
      if (stb.accept) begin
        capIdx    <= reqAddr[PAGE_BITS +: IDX_W];
        capAccess <= access_e'(reqAccess);
        capFlags  <= reqFlags;
      end
      if (stb.bypass) respFlags <= reqFlags;
      if (stb.latch) begin
        respFlags <= nextFlags;
        wbKey     <= nextKey;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PAGES; i++) keyRam[i] <= '0;
    end else begin
      if (stb.tstWrite) keyRam[tstIdx] <= tstWkey;
      if (stb.commit)   keyRam[capIdx] <= wbKey;
    end
  end

  assign tstRkey = keyRam[tstIdx];

endmodule

// File: rtl/skey_updater.sv
module skey_updater
  import skey_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reqValid,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [1:0]                   reqAccess,
  input  logic [2:0]                   reqFlags,
  input  logic [ADDR_W-1:0]            memSize,
  output logic                         respValid,
  output logic [2:0]                   respFlags,
  output logic                         busy,
  input  logic                         tstWe,
  input  logic [$clog2(NUM_PAGES)-1:0] tstIdx,
  input  logic [7:0]                   tstWkey,
  output logic [7:0]                   tstRkey
);

  strobe_t           stb;
  logic              inRange;
  access_e           capAccess;
  logic [FLAG_W-1:0] capFlags;
  logic [KEY_W-1:0]  wbKey;

  skey_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .inRange   (inRange),
    .tstWe     (tstWe),
    .stb       (stb),
    .busy      (busy),
    .respValid (respValid)
  );

  skey_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .NUM_PAGES (NUM_PAGES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqAccess (reqAccess),
    .reqFlags  (reqFlags),
    .memSize   (memSize),
    .tstIdx    (tstIdx),
    .tstWkey   (tstWkey),
    .inRange   (inRange),
    .respFlags (respFlags),
    .tstRkey   (tstRkey),
    .capAccess (capAccess),
    .capFlags  (capFlags),
    .wbKey     (wbKey)
  );

endmodule

// File: rtl/skey_updater_chk.sv
module skey_updater_chk
  import skey_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              respValid,
  input logic [FLAG_W-1:0] respFlags,
  input logic [FLAG_W-1:0] capFlags,
  input access_e           capAccess,
  input logic [KEY_W-1:0]  wbKey,
  input strobe_t           stb
);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    busy && !$past(busy) |=> busy);

  p_busy_end_r8: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |=> !busy);

  p_resp_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> respValid);

  p_bypass_idle_r1: assert property (@(posedge clk) disable iff (rst)
    respValid && !$past(busy) |-> !busy && respFlags == capFlags);

  p_flags_narrow_r4: assert property (@(posedge clk) disable iff (rst)
    respValid |-> respFlags[FL_READ] == capFlags[FL_READ] &&
                  respFlags[FL_EXEC] == capFlags[FL_EXEC] &&
                  (!respFlags[FL_WRITE] || capFlags[FL_WRITE]));

  p_store_flags_r6: assert property (@(posedge clk) disable iff (rst)
    respValid && capAccess == ACC_STORE |-> respFlags == capFlags);

  p_store_chg_r6: assert property (@(posedge clk) disable iff (rst)
    stb.commit && capAccess == ACC_STORE |-> wbKey[KEY_CHG]);

  p_ref_set_r7: assert property (@(posedge clk) disable iff (rst)
    stb.commit |-> wbKey[KEY_REF]);

  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !stb.accept && !stb.tstWrite);

endmodule

bind skey_updater skey_updater_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .respValid (respValid),
  .respFlags (respFlags),
  .capFlags  (capFlags),
  .capAccess (capAccess),
  .wbKey     (wbKey),
  .stb       (stb)
);

// File: tb/skey_updater_test.sv
module skey_updater_test;

  localparam int CLK_PERIOD = 10;
  localparam int NPAGES     = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqAccess = '0;
  logic [2:0]  reqFlags = '0;
  logic [31:0] memSize = '0;
  logic        respValid;
  logic [2:0]  respFlags;
  logic        busy;
  logic        tstWe = 1'b0;
  logic [5:0]  tstIdx = '0;
  logic [7:0]  tstWkey = '0;
  logic [7:0]  tstRkey;

  skey_updater uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqAccess(reqAccess), .reqFlags(reqFlags), .memSize(memSize),
    .respValid(respValid), .respFlags(respFlags), .busy(busy),
    .tstWe(tstWe), .tstIdx(tstIdx), .tstWkey(tstWkey), .tstRkey(tstRkey)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    done = 1'b0;
  int    busyStart = 0;
  int    busyUntil = 0;
  logic [7:0] model [NPAGES];
  int         dueQ[$];
  logic [2:0] flQ[$];
  string      tagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit modelBusy();
    return (cyc > busyStart) && (cyc < busyUntil);
  endfunction

  // Per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit    expV;
      bit    expB;
      string tg;
      expV = (dueQ.size() > 0) && (dueQ[0] == cyc);
      expB = modelBusy();
      tg   = expV ? tagQ[0] : "R8/R9";
      check(respValid == expV, {tg, " respValid"}, respValid, expV);
      check(busy == expB, "R8 busy", busy, expB);
      if (expV) begin
        check(respFlags == flQ[0], {tg, " respFlags"}, respFlags, flQ[0]);
        void'(dueQ.pop_front());
        void'(flQ.pop_front());
        void'(tagQ.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendReq(input logic [31:0] addr, input logic [1:0] acc,
                         input logic [2:0] fl, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqAccess = acc; reqFlags = fl;
    if (!modelBusy()) begin
      int pg;
      pg = int'(addr >> 12);
      if (addr >= memSize || addr >= 32'(NPAGES * 4096)) begin
        dueQ.push_back(cyc + 1); flQ.push_back(fl); tagQ.push_back(tag);
      end else begin
        logic [7:0] k;
        logic [2:0] o;
        k = model[pg];
        o = fl;
        if (acc != 2'd1 && !k[1]) o[1] = 1'b0;
        k = k | 8'h04 | ((acc == 2'd1) ? 8'h02 : 8'h00);
        model[pg] = k;
        dueQ.push_back(cyc + 3); flQ.push_back(o); tagQ.push_back(tag);
        busyStart = cyc;
        busyUntil = cyc + 3;
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic tstWrite(input int idx, input logic [7:0] key);
    @(negedge clk);
    tstWe = 1'b1; tstIdx = 6'(idx); tstWkey = key;
    if (!modelBusy()) model[idx] = key;
    @(negedge clk);
    tstWe = 1'b0;
  endtask

  task automatic keyCheck(input int idx, input string tag);
    @(negedge clk);
    tstIdx = 6'(idx);
    #1;
    check(tstRkey == model[idx], tag, tstRkey, model[idx]);
  endtask

  initial begin
    for (int i = 0; i < NPAGES; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(busy == 1'b0, "R11 busy after reset", busy, 0);
    check(respValid == 1'b0, "R11 respValid after reset", respValid, 0);
    keyCheck(5, "R11 key cleared");
    memSize = 32'(32 * 4096);

    // load, change bit clear: write withheld, reference set
    sendReq(32'h0000_3A10, 2'd0, 3'b111, "R4 load chg clear"); idle(3);
    keyCheck(3, "R7 R3 key after load");
    keyCheck(2, "R3 neighbour below");
    keyCheck(4, "R3 neighbour above");
    sendReq(32'h0000_3000, 2'd2, 3'b111, "R4 fetch chg clear"); idle(3);
    sendReq(32'h0000_3FFC, 2'd1, 3'b111, "R6 store"); idle(3);
    keyCheck(3, "R6 key after store");
    sendReq(32'h0000_3004, 2'd0, 3'b111, "R5 load chg set"); idle(3);
    sendReq(32'h0000_3004, 2'd2, 3'b110, "R5 fetch chg set"); idle(3);

    // preloaded keys keep their other bits
    tstWrite(10, 8'hF8);
    keyCheck(10, "R10 test write idle");
    sendReq(32'h0000_A000, 2'd0, 3'b011, "R7 load keeps bits"); idle(3);
    keyCheck(10, "R7 key bits kept");
    tstWrite(11, 8'h02);
    sendReq(32'h0000_B123, 2'd2, 3'b110, "R5 fetch preset chg"); idle(3);
    keyCheck(11, "R7 ref set on preset key");
    sendReq(32'h0000_C000, 2'd3, 3'b111, "R4 code 3 as load"); idle(3);
    keyCheck(12, "R4 code 3 key");
    sendReq(32'h0000_D000, 2'd1, 3'b101, "R6 store without write"); idle(3);
    keyCheck(13, "R6 change set");

    // bypass by memory size
    sendReq(32'h0002_8000, 2'd1, 3'b111, "R1 above memSize"); idle(2);
    keyCheck(40, "R1 key untouched");
    sendReq(32'h0002_0000, 2'd0, 3'b101, "R1 at memSize"); idle(2);
    keyCheck(32, "R1 key at boundary untouched");
    sendReq(32'h0001_FFFF, 2'd0, 3'b111, "R1 just below memSize"); idle(3);
    keyCheck(31, "R1 in-range key updated");

    // bypass by array depth
    memSize = 32'hFFFF_FFFF;
    sendReq(32'(70) << 12, 2'd1, 3'b111, "R2 beyond depth"); idle(2);
    keyCheck(6, "R2 aliased key untouched");

    // request while busy ignored
    sendReq(32'h0000_1000, 2'd0, 3'b111, "R8 first");
    sendReq(32'h0001_4000, 2'd1, 3'b111, "R9 ignored"); idle(3);
    keyCheck(20, "R9 key untouched");
    keyCheck(1, "R8 key updated");

    // test write while busy ignored
    sendReq(32'h0000_2000, 2'd1, 3'b111, "R8 store");
    tstWrite(21, 8'h55); idle(3);
    keyCheck(21, "R10 busy test write dropped");

    // back-to-back acceptance in the response cycle
    sendReq(32'h0000_E000, 2'd0, 3'b111, "R8 b2b first"); idle(1);
    sendReq(32'h0000_F000, 2'd1, 3'b011, "R8 b2b second"); idle(3);
    keyCheck(14, "R8 b2b key a");
    keyCheck(15, "R8 b2b key b");

    check(dueQ.size() == 0, "R8 pending responses", dueQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule